// File: doc/BRIEF.md
# Microcontroller Run Control and Mailbox

This block is the host-side control face of an embedded microcontroller. It holds a boot address, a core-select flag and two 32-bit mailbox words, and it governs when the attached core may run. After reset the block clears the core's local memories for a fixed number of cycles. Only after that does it accept a start request. A start moves the block from halted to running. A one-cycle halt pulse from the core brings it back to halted. The host polls a halted flag in the control register to see that the core has finished.

A typical use runs as follows. The host waits for the scrub-done flag, then writes the boot address, the core select and the argument words into the mailboxes, and then issues a start. The start is written to the main control register, or to its alias register when the alias-enable flag is set. The host then polls for halted and reads the exit status back from the mailboxes. The core can write either mailbox at any time. While the core runs, its writes win a same-cycle conflict. While it is halted, the host's writes win.

The state machine has four states. ST_RESET is held during reset and lasts one cycle after reset is released. ST_SCRUB covers memory clearing. ST_HALTED waits for a start. ST_RUNNING lasts until the core halts. The transitions are as follows:
- RESET to SCRUB is unconditional.
- SCRUB to HALTED happens when the scrub count expires.
- HALTED to RUNNING happens on an accepted start request.
- RUNNING to HALTED happens on a core halt pulse.

Top module: `mcu_runctl`

## Requirements
- R1: While reset is held and in the first cycle after its release, the control register reads 0 (halted=0, alias-enable=0, scrub-done=0). Mailboxes, boot address and core select are all 0, and core_run and core_start are 0.
- R2: The halted flag (control register, address 0, bit 1) and the scrub-done flag (bit 3) first read 1 exactly SCRUB_CYCLES+1 rising edges after reset is released.
- R3: A start request made before scrubbing completes is ignored. core_run stays 0 and the block still reaches halted on schedule.
- R4: With alias-enable clear and the block halted, a host write of bit 0 set to the control register (address 0) moves the block to running on that edge. After the edge, core_run=1, the halted flag reads 0, and core_start is 1 for exactly one cycle.
- R5: Alias-enable is bit 2 of a control register write and reads back in bit 2. When it is set, a start through address 0 is ignored and a start through the alias register (address 1, bit 0) is accepted. When it is clear, a start through address 1 is ignored.
- R6: A core_halt pulse while running returns the block to halted on that edge: core_run=0 and the halted flag reads 1.
- R7: A start request while running produces no new core_start pulse. A core_halt pulse while halted leaves the block halted.
- R8: Mailbox 0 (address 3) and mailbox 1 (address 4) are independent 32-bit registers. A host write to one leaves the other unchanged. Both read back through host_rdata and appear on core_mbox0/core_mbox1 one edge after the write.
- R9: While halted, when the host and the core write the same mailbox in the same cycle, the host's value is stored.
- R10: Outside the halted state, when the host and the core write the same mailbox in the same cycle, the core's value is stored.
- R11: The boot address register (address 2) reads back what the host wrote and drives core_boot_addr.
- R12: Core select (address 5, bit 0) drives core_sel. A value of 0 picks the legacy core and 1 picks the RISC-V core, and the bit reads back in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | ADDR_W | Host register word address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Read data for host_addr (combinational) |
| core_halt | input | 1 | One-cycle halt pulse from the core |
| core_mb_we | input | 2 | Core mailbox write enables, bit n for mailbox n |
| core_mb_wdata0 | input | DATA_W | Core write data for mailbox 0 |
| core_mb_wdata1 | input | DATA_W | Core write data for mailbox 1 |
| core_run | output | 1 | High while the core is running |
| core_start | output | 1 | One-cycle pulse on entry to running |
| core_boot_addr | output | DATA_W | Start address for the core |
| core_sel | output | 1 | Selected core (0 legacy, 1 RISC-V) |
| core_mbox0 | output | DATA_W | Mailbox 0 contents |
| core_mbox1 | output | DATA_W | Mailbox 1 contents |

## Verification
The embedded properties assume three things about the inputs:
- Reset is held low from time zero until the first edges have loaded the state register.
- The core raises core_halt only as a single-cycle pulse.
- The core's mailbox data is known whenever its write enable is high.

The bench drives every input on falling edges with defined values, and it pulses core_halt for one cycle at a time. The random stimulus draws mailbox writes, starts and halts from a fixed seed while alias-enable is clear. It tracks running versus halted in its own model, so that same-cycle mailbox conflicts are predicted under both priorities.

// File: rtl/runctl_pkg.sv
package runctl_pkg;
    typedef enum logic [1:0] {
        ST_RESET   = 2'd0,
        ST_SCRUB   = 2'd1,
        ST_HALTED  = 2'd2,
        ST_RUNNING = 2'd3
    } run_state_t;

    localparam int unsigned REG_CTRL    = 0;
    localparam int unsigned REG_ALIAS   = 1;
    localparam int unsigned REG_BOOTVEC = 2;
    localparam int unsigned REG_MBOX0   = 3;
    localparam int unsigned REG_MBOX1   = 4;
    localparam int unsigned REG_CORESEL = 5;

    localparam int unsigned CTL_START    = 0;
    localparam int unsigned CTL_HALTED   = 1;
    localparam int unsigned CTL_ALIAS_EN = 2;
    localparam int unsigned CTL_SCRUBBED = 3;

    localparam int unsigned NUM_MBOX = 2;
endpackage

// File: rtl/runctl_fsm.sv
module runctl_fsm
    import runctl_pkg::*;
#(
    parameter int unsigned SCRUB_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_req,
    input  logic       halt_pulse,
    output run_state_t state,
    output logic       halted,
    output logic       running,
    output logic       scrub_done,
    output logic       core_start
);
    localparam int unsigned CNT_W = $clog2(SCRUB_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SCRUB_CYCLES - 1);
    localparam logic [CNT_W-1:0] CNT_LIM  = CNT_W'(SCRUB_CYCLES);

    run_state_t       state_d;
    logic [CNT_W-1:0] scrub_cnt;
    logic             go;

    always_comb begin
        state_d = state;
        go      = 1'b0;
        unique case (state)
            ST_RESET:   state_d = ST_SCRUB;
            ST_SCRUB:   if (scrub_cnt == CNT_LAST) state_d = ST_HALTED;
            ST_HALTED:  if (start_req) begin
                            state_d = ST_RUNNING;
                            go      = 1'b1;
                        end
            ST_RUNNING: if (halt_pulse) state_d = ST_HALTED;
        endcase
    end

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_RESET;
            scrub_cnt  <= '0;
            core_start <= 1'b0;
        end else begin
            state      <= state_d;
            core_start <= go;
            if (state == ST_SCRUB) scrub_cnt <= scrub_cnt + 1'b1;
            else                   scrub_cnt <= '0;
        end
    end

    // Output process
    always_comb begin
        halted     = 1'b0;
        running    = 1'b0;
        scrub_done = 1'b0;
        unique case (state)
            ST_RESET, ST_SCRUB: ;
            ST_HALTED:  begin halted  = 1'b1; scrub_done = 1'b1; end
            ST_RUNNING: begin running = 1'b1; scrub_done = 1'b1; end
        endcase
    end

    assert_scrub_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCRUB) |-> (scrub_cnt < CNT_LIM));

    assert_run_after_scrub_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUNNING) |-> ($past(state) == ST_HALTED || $past(state) == ST_RUNNING));

    assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |-> (state == ST_RUNNING && $past(state) == ST_HALTED));

    assert_halt_returns_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUNNING && halt_pulse) |=> (state == ST_HALTED && !core_start));

    assert_state_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({halted, running}));
endmodule

// File: rtl/runctl_regs.sv
module runctl_regs
    import runctl_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          host_wr,
    input  logic [ADDR_W-1:0]             host_addr,
    input  logic [DATA_W-1:0]             host_wdata,
    input  logic                          halted,
    input  logic                          scrub_done,
    input  logic [NUM_MBOX-1:0][DATA_W-1:0] mb_q,
    output logic                          start_req,
    output logic [NUM_MBOX-1:0]           host_mb_we,
    output logic [DATA_W-1:0]             boot_addr,
    output logic                          core_sel,
    output logic [DATA_W-1:0]             rdata
);
    localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(REG_CTRL);
    localparam logic [ADDR_W-1:0] A_ALIAS   = ADDR_W'(REG_ALIAS);
    localparam logic [ADDR_W-1:0] A_BOOTVEC = ADDR_W'(REG_BOOTVEC);
    localparam logic [ADDR_W-1:0] A_CORESEL = ADDR_W'(REG_CORESEL);

    logic alias_en;
    logic wr_ctrl, wr_alias;

    assign wr_ctrl  = host_wr && (host_addr == A_CTRL);
    assign wr_alias = host_wr && (host_addr == A_ALIAS);

    // Start gate: only the path selected by the alias-enable flag counts
    assign start_req = host_wdata[CTL_START] &&
                       (alias_en ? wr_alias : wr_ctrl);

    for (genvar i = 0; i < NUM_MBOX; i++) begin : g_mb_dec
        assign host_mb_we[i] = host_wr && (host_addr == ADDR_W'(REG_MBOX0 + i));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alias_en  <= 1'b0;
            boot_addr <= '0;
            core_sel  <= 1'b0;
        end else begin
            if (wr_ctrl) alias_en <= host_wdata[CTL_ALIAS_EN];
            if (host_wr && host_addr == A_BOOTVEC) boot_addr <= host_wdata;
            if (host_wr && host_addr == A_CORESEL) core_sel  <= host_wdata[0];
        end
    end

    always_comb begin
        rdata = '0;
        if (host_addr == A_CTRL || host_addr == A_ALIAS) begin
            rdata[CTL_HALTED]   = halted;
            rdata[CTL_ALIAS_EN] = alias_en;
            rdata[CTL_SCRUBBED] = scrub_done;
        end else if (host_addr == A_BOOTVEC) begin
            rdata = boot_addr;
        end else if (host_addr == A_CORESEL) begin
            rdata[0] = core_sel;
        end else begin
            for (int i = 0; i < NUM_MBOX; i++)
                if (host_addr == ADDR_W'(REG_MBOX0 + i)) rdata = mb_q[i];
        end
    end

    assert_bootvec_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && host_addr == A_BOOTVEC) |=> $stable(boot_addr));
endmodule

// File: rtl/runctl_mbox.sv
module runctl_mbox #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_prio,
    input  logic              host_we,
    input  logic [DATA_W-1:0] host_data,
    input  logic              core_we,
    input  logic [DATA_W-1:0] core_data,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (host_we && core_we) begin
            q <= host_prio ? host_data : core_data;
        end else if (host_we) begin
            q <= host_data;
        end else if (core_we) begin
            q <= core_data;
        end
    end

    assert_host_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_prio && host_we) |=> (q == $past(host_data)));

    assert_core_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_prio && core_we) |=> (q == $past(core_data)));

    assert_mbox_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_we && !core_we) |=> $stable(q));
endmodule

// File: rtl/mcu_runctl.sv
module mcu_runctl
    import runctl_pkg::*;
#(
    parameter int unsigned DATA_W       = 32,
    parameter int unsigned ADDR_W       = 3,
    parameter int unsigned SCRUB_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              core_halt,
    input  logic [1:0]        core_mb_we,
    input  logic [DATA_W-1:0] core_mb_wdata0,
    input  logic [DATA_W-1:0] core_mb_wdata1,
    output logic              core_run,
    output logic              core_start,
    output logic [DATA_W-1:0] core_boot_addr,
    output logic              core_sel,
    output logic [DATA_W-1:0] core_mbox0,
    output logic [DATA_W-1:0] core_mbox1
);
    run_state_t                    state;
    logic                          halted, scrub_done, start_req;
    logic [NUM_MBOX-1:0]           host_mb_we;
    logic [NUM_MBOX-1:0][DATA_W-1:0] mb_q;
    logic [NUM_MBOX-1:0][DATA_W-1:0] core_wd;

    assign core_wd[0] = core_mb_wdata0;
    assign core_wd[1] = core_mb_wdata1;

    runctl_fsm #(.SCRUB_CYCLES(SCRUB_CYCLES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_req  (start_req),
        .halt_pulse (core_halt),
        .state      (state),
        .halted     (halted),
        .running    (core_run),
        .scrub_done (scrub_done),
        .core_start (core_start)
    );

    runctl_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .halted     (halted),
        .scrub_done (scrub_done),
        .mb_q       (mb_q),
        .start_req  (start_req),
        .host_mb_we (host_mb_we),
        .boot_addr  (core_boot_addr),
        .core_sel   (core_sel),
        .rdata      (host_rdata)
    );

    for (genvar i = 0; i < NUM_MBOX; i++) begin : g_mbox
        runctl_mbox #(.DATA_W(DATA_W)) u_mbox (
            .clk       (clk),
            .rst_n     (rst_n),
            .host_prio (halted),
            .host_we   (host_mb_we[i]),
            .host_data (host_wdata),
            .core_we   (core_mb_we[i]),
            .core_data (core_wd[i]),
            .q         (mb_q[i])
        );
    end

    assign core_mbox0 = mb_q[0];
    assign core_mbox1 = mb_q[1];

    assert_start_needs_halted_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_run) |-> $past(state) == ST_HALTED);
endmodule

// File: tb/mcu_runctl_bench.sv
module mcu_runctl_bench;
    localparam int unsigned DW = 32;
    localparam int unsigned AW = 3;
    localparam int unsigned SC = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_wr = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata;
    logic          core_halt = 1'b0;
    logic [1:0]    core_mb_we = 2'b00;
    logic [DW-1:0] core_mb_wdata0 = '0;
    logic [DW-1:0] core_mb_wdata1 = '0;
    logic          core_run, core_start, core_sel;
    logic [DW-1:0] core_boot_addr, core_mbox0, core_mbox1;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    mcu_runctl #(.DATA_W(DW), .ADDR_W(AW), .SCRUB_CYCLES(SC)) u_mcu_runctl (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .core_halt(core_halt),
        .core_mb_we(core_mb_we), .core_mb_wdata0(core_mb_wdata0),
        .core_mb_wdata1(core_mb_wdata1), .core_run(core_run), .core_start(core_start),
        .core_boot_addr(core_boot_addr), .core_sel(core_sel),
        .core_mbox0(core_mbox0), .core_mbox1(core_mbox1)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] mbox_next(input logic [DW-1:0] old, input bit hw,
            input logic [DW-1:0] hd, input bit cw, input logic [DW-1:0] cd, input bit is_halted);
        if (hw && cw) return is_halted ? hd : cd;
        if (hw) return hd;
        if (cw) return cd;
        return old;
    endfunction

    task automatic host_write(input int unsigned a, input logic [DW-1:0] d);
        host_wr = 1'b1; host_addr = AW'(a); host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input int unsigned a, output logic [DW-1:0] d);
        host_addr = AW'(a);
        #1;
        d = host_rdata;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [DW-1:0] rd, bv, m0, m1, hd, c0, c1;
        bit exp_run;
        int seen;
        void'($urandom(32'd7341));

        // R1: reset state
        repeat (3) @(negedge clk);
        host_read(0, rd);           check("R1 ctrl in reset", rd, '0);
        check("R1 run", {31'b0, core_run}, 0);
        check("R1 mbox0", core_mbox0, '0);
        check("R1 mbox1", core_mbox1, '0);
        check("R1 bootvec", core_boot_addr, '0);
        check("R1 coresel", {31'b0, core_sel}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        host_read(0, rd);           check("R1 ctrl after release", rd, '0);

        // R2/R3: scrub duration, early start ignored
        seen = 0;
        for (int k = 2; k <= SC + 4; k++) begin
            if (k == 4) begin host_wr = 1'b1; host_addr = AW'(0); host_wdata = 32'h1; end
            @(negedge clk);
            host_wr = 1'b0;
            host_read(0, rd);
            if (seen == 0 && rd[1]) seen = k;
            if (core_run) begin n_errors++; $display("FAIL R3 actual=run expected=idle"); end
        end
        n_checks++;
        check("R2 cycles to halted", seen, SC + 1);
        host_read(0, rd);           check("R2 ctrl halted+scrubbed", rd, 32'hA);
        check("R3 not running", {31'b0, core_run}, 0);

        // R11/R12
        bv = $urandom;
        host_write(2, bv);
        host_read(2, rd);           check("R11 bootvec read", rd, bv);
        check("R11 bootvec out", core_boot_addr, bv);
        host_write(5, 32'h1);
        check("R12 riscv select", {31'b0, core_sel}, 1);
        host_read(5, rd);           check("R12 read", rd, 32'h1);
        host_write(5, 32'h0);
        check("R12 legacy select", {31'b0, core_sel}, 0);

        // R8: independent mailboxes
        m0 = $urandom; m1 = $urandom;
        host_write(3, m0);
        check("R8 mbox1 untouched", core_mbox1, '0);
        host_write(4, m1);
        host_read(3, rd);           check("R8 mbox0 read", rd, m0);
        host_read(4, rd);           check("R8 mbox1 read", rd, m1);
        check("R8 mbox0 out", core_mbox0, m0);

        // R4: start through main register
        host_write(0, 32'h1);
        check("R4 start pulse", {31'b0, core_start}, 1);
        check("R4 run", {31'b0, core_run}, 1);
        host_read(0, rd);           check("R4 halted cleared", rd, 32'h8);
        @(negedge clk);
        check("R4 pulse one cycle", {31'b0, core_start}, 0);

        // R7: start while running
        host_write(0, 32'h1);
        check("R7 no restart pulse", {31'b0, core_start}, 0);
        check("R7 still running", {31'b0, core_run}, 1);

        // R10: core wins while running
        hd = 32'h1111_2222; c0 = 32'h3333_4444;
        host_wr = 1'b1; host_addr = AW'(3); host_wdata = hd;
        core_mb_we = 2'b01; core_mb_wdata0 = c0;
        @(negedge clk);
        host_wr = 1'b0; core_mb_we = 2'b00;
        check("R10 core wins", core_mbox0, c0);

        // R6: halt pulse
        core_halt = 1'b1;
        @(negedge clk);
        core_halt = 1'b0;
        check("R6 run cleared", {31'b0, core_run}, 0);
        host_read(0, rd);           check("R6 halted", rd, 32'hA);

        // R7: halt while halted
        core_halt = 1'b1;
        @(negedge clk);
        core_halt = 1'b0;
        host_read(0, rd);           check("R7 halt in halted", rd, 32'hA);

        // R9: host wins while halted
        hd = 32'h5555_6666; c1 = 32'h7777_8888;
        host_wr = 1'b1; host_addr = AW'(4); host_wdata = hd;
        core_mb_we = 2'b10; core_mb_wdata1 = c1;
        @(negedge clk);
        host_wr = 1'b0; core_mb_we = 2'b00;
        check("R9 host wins", core_mbox1, hd);

        // R5: alias gating
        host_write(0, 32'h4);
        host_read(0, rd);           check("R5 alias flag", rd, 32'hE);
        host_write(0, 32'h5);
        check("R5 main start ignored", {31'b0, core_run}, 0);
        host_write(1, 32'h1);
        check("R5 alias start", {31'b0, core_run}, 1);
        core_halt = 1'b1;
        @(negedge clk);
        core_halt = 1'b0;
        host_write(0, 32'h0);
        host_write(1, 32'h1);
        check("R5 alias ignored when off", {31'b0, core_run}, 0);

        // Random phase: R8/R9/R10/R4/R6
        m0 = core_mbox0; m1 = core_mbox1; exp_run = 0;
        for (int it = 0; it < 400; it++) begin
            int unsigned kind;
            bit hw0, hw1, st, hl;
            kind = $urandom % 8;
            hd = $urandom; c0 = $urandom; c1 = $urandom;
            hw0 = (kind <= 2); hw1 = (kind == 3 || kind == 4); st = (kind == 5);
            host_wr = hw0 || hw1 || st;
            host_addr = hw0 ? AW'(3) : hw1 ? AW'(4) : AW'(0);
            host_wdata = st ? 32'h1 : hd;
            core_mb_we = 2'($urandom);
            core_mb_wdata0 = c0; core_mb_wdata1 = c1;
            hl = ($urandom % 6 == 0);
            core_halt = hl;
            m0 = mbox_next(m0, hw0, hd, core_mb_we[0], c0, !exp_run);
            m1 = mbox_next(m1, hw1, hd, core_mb_we[1], c1, !exp_run);
            if (!exp_run && st) exp_run = 1;
            else if (exp_run && hl) exp_run = 0;
            @(negedge clk);
            host_wr = 1'b0; core_mb_we = 2'b00; core_halt = 1'b0;
            check("R9/R10 random mbox0", core_mbox0, m0);
            check("R8 random mbox1", core_mbox1, m1);
            check("R4/R6 random run", {31'b0, core_run}, {31'b0, exp_run});
        end

        finish_run();
    end
endmodule